// File: doc/BRIEF.md
# Peripheral reset and clock request register

This block keeps the reset lines for a group of up to 32 peripherals behind a small 32-bit register port. Each line has an active-low request bit: writing 0 holds the peripheral in reset, writing 1 lets it run. A status word reports, per line, whether the peripheral has actually reached the requested state. Status is active-low in the same sense: 0 means held in reset. The status model lags each request by a fixed number of core clocks, so the polling loop that software runs against the status word can be exercised in simulation.

A build parameter picks one of two layouts. The reset-only layout has one request word and one status word, and each clock enable follows its reset request. The paired layout adds a clock-gating request word and a clock status word. Software writes the same value to both request words. A line counts as finished only when both of its status bits have caught up with their requests. A valid mask marks which bit positions are backed by a peripheral. Positions outside the mask are holes: they stay in reset, they read as 0, and writes to them have no effect.

The register port is plain control. A write is taken on any cycle in which `reg_wr_i` is high. A read returns data with a one-cycle latency and never stalls, so there is no back-pressure. Outputs are registered request levels and a per-line settled flag.

Top module: `periph_reset_ctl`

## Requirements
- R1: After power-on reset, every request bit is 0, `rst_n_o` and `clk_en_o` are all 0, every register reads 0, and `settled_o` equals the valid mask.
- R2: Writing the reset request word (offset 0x0) sets `rst_n_o` to the written value ANDed with the valid mask from the cycle after the write edge. Bit i set to 1 releases line i; bit i set to 0 holds it in reset. Other lines keep their values.
- R3: A valid line's reset status bit takes the new value of its request bit exactly RST_SETTLE clocks after the write edge, in both the release and the assert direction.
- R4: A status bit only ever moves to its request's current value. If a request returns to its old value before the delay runs out, the status bit never changes.
- R5: Request and status bits outside VALID_MASK read as 0, ignore writes and drive 0 on `rst_n_o` and `clk_en_o`.
- R6: Paired layout (PAIRED=1) offsets: reset request 0x0, clock status 0x4, reset status 0x8, clock request 0xC. `clk_en_o` follows the clock request word, and clock status follows it after CLK_SETTLE clocks.
- R7: Reset-only layout (PAIRED=0) offsets: request 0x0, status 0x4. Offsets 0x8 and 0xC read 0 and ignore writes. `clk_en_o` equals `rst_n_o`.
- R8: `settled_o[i]` is high for a valid line only when its reset status equals its reset request and, in the paired layout, its clock status equals its clock request.
- R9: Writes to status offsets or to undecoded offsets change no request bit.
- R10: A read presented with `reg_rd_i` returns its data on `reg_rdata_o` with `reg_rvalid_o` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| reg_rvalid_o | output | 1 | Read data valid |
| rst_n_o | output | NUM_LINES | Per-line active-low reset request |
| clk_en_o | output | NUM_LINES | Per-line clock enable |
| settled_o | output | NUM_LINES | Per-line transition-finished flag |

## Verification
The hardest case to reach is a line that is only half finished in the paired layout: its reset status has already caught up, but its clock status has not. The two settle delays differ, and the bench writes the clock request one cycle after the reset request. It then reads both status words inside that window and checks that the settled flag stays low until the slower bit arrives. A second hard case is a request pulse shorter than the delay. The bench sets a bit and clears it on the following cycle, then watches that line's settled flag on every cycle afterwards.

// File: rtl/prc_pkg.sv
package prc_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RST_REQ,
    SEL_RST_STS,
    SEL_CLK_REQ,
    SEL_CLK_STS
  } reg_sel_e;

  // Offset 0x0 is the reset request in both layouts; the rest depends on layout.
  function automatic reg_sel_e decode_offset(input logic [7:0] ofs, input logic paired);
    reg_sel_e sel;
    sel = SEL_NONE;
    case (ofs)
      8'h00: sel = SEL_RST_REQ;
      8'h04: sel = paired ? SEL_CLK_STS : SEL_RST_STS;
      8'h08: sel = paired ? SEL_RST_STS : SEL_NONE;
      8'h0C: sel = paired ? SEL_CLK_REQ : SEL_NONE;
      default: sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/prc_line_settle.sv
module prc_line_settle #(
  parameter int unsigned DELAY = 4,
  localparam int unsigned CW = $clog2(DELAY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic target_i,
  output logic status_o
);

  logic          sts_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0;
      cnt_q <= '0;
    end else if (target_i == sts_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DELAY - 1)) begin
      sts_q <= target_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign status_o = sts_q;

  // R4: a status change always lands on the value the request held
  a_r4_moves_to_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sts_q) |-> sts_q == $past(target_i));

  // R3: no movement while status already matches the request
  a_r3_quiet_when_matched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (target_i == sts_q) |=> $stable(sts_q));

endmodule

// File: rtl/prc_status_bank.sv
module prc_status_bank #(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned DELAY      = 4,
  parameter logic [31:0] VALID_MASK = 32'h0000_1F7F
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  output logic [NUM_LINES-1:0] sts_o
);

  localparam logic [NUM_LINES-1:0] VMASK = VALID_MASK[NUM_LINES-1:0];

  logic [NUM_LINES-1:0] target;
  assign target = req_i & VMASK;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    prc_line_settle #(.DELAY(DELAY)) i_settle (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .target_i (target[i]),
      .status_o (sts_o[i])
    );
  end

endmodule

// File: rtl/prc_regs.sv
module prc_regs
  import prc_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned ADDR_W     = 4,
  parameter bit          PAIRED     = 1'b1,
  parameter logic [31:0] VALID_MASK = 32'h0000_1F7F
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  output logic [WORD_W-1:0]    reg_rdata_o,
  output logic                 reg_rvalid_o,
  input  logic [NUM_LINES-1:0] rst_sts_i,
  input  logic [NUM_LINES-1:0] clk_sts_i,
  output logic [NUM_LINES-1:0] rst_req_o,
  output logic [NUM_LINES-1:0] clk_req_o
);

  localparam logic [NUM_LINES-1:0] VMASK = VALID_MASK[NUM_LINES-1:0];

  reg_sel_e             sel;
  logic [NUM_LINES-1:0] rst_req_q, clk_req_q;
  logic [NUM_LINES-1:0] wbits;
  logic [WORD_W-1:0]    rd_word;
  logic [WORD_W-1:0]    rdata_q;
  logic                 rvalid_q;

  assign sel   = decode_offset(8'(reg_addr_i), PAIRED);
  assign wbits = reg_wdata_i[NUM_LINES-1:0] & VMASK;

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_RST_REQ: rd_word[NUM_LINES-1:0] = rst_req_q;
      SEL_CLK_REQ: rd_word[NUM_LINES-1:0] = clk_req_q;
      SEL_RST_STS: rd_word[NUM_LINES-1:0] = rst_sts_i & VMASK;
      SEL_CLK_STS: rd_word[NUM_LINES-1:0] = clk_sts_i & VMASK;
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_q <= '0;
      clk_req_q <= '0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      rvalid_q <= reg_rd_i;
      if (reg_rd_i) rdata_q <= rd_word;
      if (reg_wr_i && sel == SEL_RST_REQ) rst_req_q <= wbits;
      if (reg_wr_i && sel == SEL_CLK_REQ) clk_req_q <= wbits;
    end
  end

  assign rst_req_o    = rst_req_q;
  assign clk_req_o    = clk_req_q;
  assign reg_rdata_o  = rdata_q;
  assign reg_rvalid_o = rvalid_q;

  // R9: status or undecoded writes leave both request words alone
  a_r9_ro_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && (sel == SEL_NONE || sel == SEL_RST_STS || sel == SEL_CLK_STS))
      |=> ($stable(rst_req_q) && $stable(clk_req_q)));

  // R10: every read strobe yields valid data one cycle later
  a_r10_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i |=> reg_rvalid_o);

  // R2 / R5: a reset request write lands masked by the valid mask
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && sel == SEL_RST_REQ)
      |=> rst_req_q == ($past(reg_wdata_i[NUM_LINES-1:0]) & VMASK));

endmodule

// File: rtl/periph_reset_ctl.sv
module periph_reset_ctl #(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned ADDR_W     = 4,
  parameter bit          PAIRED     = 1'b1,
  parameter logic [31:0] VALID_MASK = 32'h0000_1F7F,
  parameter int unsigned RST_SETTLE = 4,
  parameter int unsigned CLK_SETTLE = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic                 reg_rvalid_o,
  output logic [NUM_LINES-1:0] rst_n_o,
  output logic [NUM_LINES-1:0] clk_en_o,
  output logic [NUM_LINES-1:0] settled_o
);

  localparam logic [NUM_LINES-1:0] VMASK = VALID_MASK[NUM_LINES-1:0];

  logic [NUM_LINES-1:0] rst_req, clk_req, rst_sts, clk_sts;

  prc_regs #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .PAIRED    (PAIRED),
    .VALID_MASK(VALID_MASK)
  ) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .reg_rvalid_o(reg_rvalid_o),
    .rst_sts_i   (rst_sts),
    .clk_sts_i   (clk_sts),
    .rst_req_o   (rst_req),
    .clk_req_o   (clk_req)
  );

  prc_status_bank #(
    .NUM_LINES (NUM_LINES),
    .DELAY     (RST_SETTLE),
    .VALID_MASK(VALID_MASK)
  ) i_rst_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (rst_req),
    .sts_o (rst_sts)
  );

  if (PAIRED) begin : g_paired
    prc_status_bank #(
      .NUM_LINES (NUM_LINES),
      .DELAY     (CLK_SETTLE),
      .VALID_MASK(VALID_MASK)
    ) i_clk_bank (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (clk_req),
      .sts_o (clk_sts)
    );
    assign clk_en_o  = clk_req;
    assign settled_o = VMASK & ~(rst_req ^ rst_sts) & ~(clk_req ^ clk_sts);
  end else begin : g_solo
    assign clk_sts   = '0;
    assign clk_en_o  = rst_req;
    assign settled_o = VMASK & ~(rst_req ^ rst_sts);
  end

  assign rst_n_o = rst_req;

endmodule

// File: tb/test_periph_reset_ctl.sv
`timescale 1ns/1ps
module test_periph_reset_ctl;

  localparam int unsigned N = 32;
  localparam logic [31:0] VM_P = 32'h0000_1F7F;
  localparam logic [31:0] VM_R = 32'h0FFF_FFF8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr_p = 0, rd_p = 0, wr_r = 0, rd_r = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_p, rdata_r;
  logic        rv_p, rv_r;
  logic [N-1:0] rstn_p, clken_p, setl_p, rstn_r, clken_r, setl_r;

  periph_reset_ctl i_periph_reset_ctl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr_p), .reg_rd_i(rd_p),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_p),
    .reg_rvalid_o(rv_p), .rst_n_o(rstn_p), .clk_en_o(clken_p), .settled_o(setl_p)
  );

  periph_reset_ctl #(.PAIRED(1'b0), .VALID_MASK(VM_R), .RST_SETTLE(3)) i_periph_reset_ctl_ro (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr_r), .reg_rd_i(rd_r),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_r),
    .reg_rvalid_o(rv_r), .rst_n_o(rstn_r), .clk_en_o(clken_r), .settled_o(setl_r)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] exp_q_p[$];
  string       tag_q_p[$];
  logic [31:0] exp_q_r[$];
  string       tag_q_r[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rv_p) begin
      if (exp_q_p.size() == 0) chk("R10 unexpected read", 32'd1, 32'd0);
      else chk(tag_q_p.pop_front(), rdata_p, exp_q_p.pop_front());
    end
    if (rv_r) begin
      if (exp_q_r.size() == 0) chk("R10 unexpected read", 32'd1, 32'd0);
      else chk(tag_q_r.pop_front(), rdata_r, exp_q_r.pop_front());
    end
  end

  // All tasks start and end at a falling edge.
  task automatic wr(input bit ro, input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d;
    if (ro) wr_r = 1; else wr_p = 1;
    @(posedge clk);
    @(negedge clk);
    wr_r = 0; wr_p = 0;
  endtask

  task automatic rd(input bit ro, input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    if (ro) begin rd_r = 1; exp_q_r.push_back(exp); tag_q_r.push_back(tag); end
    else    begin rd_p = 1; exp_q_p.push_back(exp); tag_q_p.push_back(tag); end
    @(posedge clk);
    @(negedge clk);
    chk("R10 rvalid after read", {31'd0, ro ? rv_r : rv_p}, 32'd1);
    rd_r = 0; rd_p = 0;
  endtask

  task automatic wait_settle(input bit ro, input int b, output int n);
    n = 0;
    while (!(ro ? setl_r[b] : setl_p[b]) && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit stayed;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rst_n_o paired", rstn_p, 0);
    chk("R1 clk_en_o paired", clken_p, 0);
    chk("R1 settled paired", setl_p, VM_P);
    chk("R1 rst_n_o solo", rstn_r, 0);
    chk("R1 clk_en_o solo", clken_r, 0);
    rd(0, 4'h0, 0, "R1 rst req reset");
    rd(0, 4'h4, 0, "R1 clk sts reset");
    rd(0, 4'h8, 0, "R1 rst sts reset");
    rd(0, 4'hC, 0, "R1 clk req reset");

    // R2/R3: release line 2 reset, then its clock (R6)
    wr(0, 4'h0, 32'h4);
    chk("R2 release line 2", rstn_p, 32'h4);
    wait_settle(0, 2, n);
    chk("R3 release settle cycles", n, 4);
    wr(0, 4'hC, 32'h4);
    chk("R6 clk_en follows clk req", clken_p, 32'h4);
    wait_settle(0, 2, n);
    chk("R6 clk settle cycles", n, 9);

    // R8: half-finished line 5
    wr(0, 4'h0, 32'h24);
    wr(0, 4'hC, 32'h24);
    repeat (5) @(negedge clk);
    rd(0, 4'h8, 32'h24, "R8 rst sts done first");
    rd(0, 4'h4, 32'h04, "R8 clk sts still pending");
    @(negedge clk);
    chk("R8 not settled before clk sts", setl_p[5], 0);
    @(negedge clk);
    chk("R8 settled when both match", setl_p[5], 1);

    // R2 read-modify-write: clear line 2, others undisturbed; R3 assert direction
    rd(0, 4'h0, 32'h24, "R2 readback before rmw");
    wr(0, 4'h0, 32'h24 & ~32'h4);
    chk("R2 rmw keeps other lines", rstn_p, 32'h20);
    wait_settle(0, 2, n);
    chk("R3 assert settle cycles", n, 4);

    // R4: short pulse on line 0
    wr(0, 4'h0, 32'h21);
    wr(0, 4'h0, 32'h20);
    stayed = 1;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (!setl_p[0]) stayed = 0;
    end
    chk("R4 short pulse status unmoved", stayed, 1);
    rd(0, 4'h8, 32'h20, "R4 rst sts after pulse");

    // R5: holes and masked bits
    wr(0, 4'h0, 32'hFFFF_FFFF);
    chk("R5 rst_n_o masked", rstn_p, VM_P);
    wr(0, 4'hC, 32'hFFFF_FFFF);
    chk("R5 clk_en_o masked", clken_p, VM_P);
    rd(0, 4'h0, VM_P, "R5 rst req masked");
    rd(0, 4'hC, VM_P, "R5 clk req masked");
    repeat (12) @(negedge clk);
    rd(0, 4'h8, VM_P, "R5 rst sts masked");
    rd(0, 4'h4, VM_P, "R5 clk sts masked");
    chk("R5 settled masked", setl_p, VM_P);

    // R9: status/undecoded writes ignored
    wr(0, 4'h8, 32'h0);
    wr(0, 4'h4, 32'h0);
    wr(0, 4'h6, 32'h0);
    chk("R9 rst_n_o unchanged", rstn_p, VM_P);
    chk("R9 clk_en_o unchanged", clken_p, VM_P);
    rd(0, 4'h0, VM_P, "R9 rst req unchanged");
    rd(0, 4'h8, VM_P, "R9 rst sts unchanged");
    rd(0, 4'h6, 32'h0, "R9 undecoded reads zero");

    // R7: reset-only layout
    chk("R1 settled solo", setl_r, VM_R);
    rd(1, 4'h8, 0, "R7 solo 0x8 zero");
    wr(1, 4'h0, 32'hFFFF_FFFF);
    chk("R7 solo rst_n_o", rstn_r, VM_R);
    chk("R7 solo clk_en equals rst_n", clken_r, VM_R);
    wait_settle(1, 3, n);
    chk("R3 solo settle cycles", n, 3);
    wr(1, 4'hC, 32'h0);
    rd(1, 4'h0, VM_R, "R7 solo 0xC write ignored");
    rd(1, 4'h4, VM_R, "R7 solo status at 0x4");
    rd(1, 4'hC, 0, "R7 solo 0xC reads zero");
    chk("R7 solo clk_en after 0xC write", clken_r, VM_R);

    repeat (3) @(negedge clk);
    chk("R10 scoreboard drained", exp_q_p.size() + exp_q_r.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule